// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This purely combinational unit sits between a 32-bit load/store core and a memory that is organised as whole 32-bit words. From a base register value, a 16-bit signed displacement, and the memory opcode, it forms the effective byte address. It also forms the word address presented to memory and a command code for the memory.

For stores, the unit copies the source register's byte or halfword into every lane it could occupy. It then raises only the write enables of the lanes that the address selects. For loads, it takes the addressed byte, halfword or word out of the returned memory word. It places that value at the bottom of the result and fills the upper bits with zeros or with copies of the sign bit.

Byte lanes are little-endian: lane k holds bits 8k+7:8k. An access that does not fit its natural alignment is flagged, and no memory command is issued for it.

Top module: `lsu_lane_align`

## Requirements
- R1: `eff_addr` always equals `base` plus `disp` sign-extended from bit 15, modulo 2^32, and `word_addr` is bits 31:2 of that sum.
- R2: `mem_cmd` is 1 (read) for an aligned load and 2 (write) for an aligned store. It is 0 for a misaligned access or for any opcode outside the eight listed here.
- R3: Opcode 100000 (signed byte load) returns lane `eff_addr[1:0]` of `rdata` in bits 7:0, with bit 7 copied into bits 31:8.
- R4: Opcode 100100 (unsigned byte load) returns the same lane in bits 7:0, with bits 31:8 cleared.
- R5: Opcodes 100001 (signed) and 100101 (unsigned) load the halfword `rdata[31:16]` when `eff_addr[1]` is 1, and `rdata[15:0]` otherwise. The halfword goes into bits 15:0, and bits 31:16 are sign-filled or cleared, respectively.
- R6: Opcode 100011 (word load) returns `rdata` unchanged.
- R7: Opcode 101000 (byte store) sets exactly one write enable, bit `eff_addr[1:0]` of `byte_we`. `wdata` carries `rt[7:0]` in all four lanes.
- R8: Opcode 101001 (halfword store) sets `byte_we` to 0011 when `eff_addr[1]` is 0 and to 1100 when it is 1. `wdata` carries `rt[15:0]` in both halves.
- R9: Opcode 101011 (word store) sets `byte_we` to 1111, with `wdata` equal to `rt`.
- R10: `misaligned` is set for a halfword load or store with `eff_addr[0]`=1, and for a word load or store with `eff_addr[1:0]`≠0. When it is set, `byte_we` is 0, `mem_cmd` is 0 and `load_val` is 0. Byte accesses are never misaligned.
- R11: For any opcode that is not a load, `load_val` is 0. For any opcode that is not a store, `byte_we` and `wdata` are 0. For an unlisted opcode, `misaligned` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement from the instruction |
| rt | input | 32 | Store source register |
| opcode | input | 6 | Primary opcode of the memory instruction |
| rdata | input | 32 | Word returned by memory |
| eff_addr | output | 32 | Effective byte address |
| word_addr | output | 30 | Word index presented to memory |
| mem_cmd | output | 2 | 0 idle, 1 read, 2 write |
| byte_we | output | 4 | Per-lane write enables, bit k for bits 8k+7:8k |
| wdata | output | 32 | Lane-replicated store data |
| load_val | output | 32 | Extended load result |
| misaligned | output | 1 | Alignment fault flag |

## Verification
The address adder and the alignment check share one cycle with lane selection. The low bits of the sum, not of `base`, decide both the lane and the fault. The sweep forces this by pairing every low-bit value of `base` with negative and positive displacements whose own low bits vary, so that carries and borrows reach bits 1:0. Each case is judged by computing the sum, lane, fault, enables and extended value arithmetically in the bench and comparing every output port.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align (
  input  logic [31:0] base,
  input  logic [15:0] disp,
  input  logic [31:0] rt,
  input  logic [5:0]  opcode,
  input  logic [31:0] rdata,
  output logic [31:0] eff_addr,
  output logic [29:0] word_addr,
  output logic [1:0]  mem_cmd,
  output logic [3:0]  byte_we,
  output logic [31:0] wdata,
  output logic [31:0] load_val,
  output logic        misaligned
);
  localparam logic [5:0] OP_LDB  = 6'b100000;
  localparam logic [5:0] OP_LDH  = 6'b100001;
  localparam logic [5:0] OP_LDW  = 6'b100011;
  localparam logic [5:0] OP_LDBU = 6'b100100;
  localparam logic [5:0] OP_LDHU = 6'b100101;
  localparam logic [5:0] OP_STB  = 6'b101000;
  localparam logic [5:0] OP_STH  = 6'b101001;
  localparam logic [5:0] OP_STW  = 6'b101011;

  logic is_ld, is_st, sz_b, sz_h, sz_w;
  logic [7:0]  lane_byte;
  logic [15:0] lane_half;

  assign eff_addr  = base + {{16{disp[15]}}, disp};
  assign word_addr = eff_addr[31:2];

  always_comb begin
    is_ld = 1'b0; is_st = 1'b0; sz_b = 1'b0; sz_h = 1'b0; sz_w = 1'b0;
    case (opcode)
      OP_LDB, OP_LDBU: begin is_ld = 1'b1; sz_b = 1'b1; end
      OP_LDH, OP_LDHU: begin is_ld = 1'b1; sz_h = 1'b1; end
      OP_LDW:          begin is_ld = 1'b1; sz_w = 1'b1; end
      OP_STB:          begin is_st = 1'b1; sz_b = 1'b1; end
      OP_STH:          begin is_st = 1'b1; sz_h = 1'b1; end
      OP_STW:          begin is_st = 1'b1; sz_w = 1'b1; end
      default: ;
    endcase
  end

  assign misaligned = (sz_h & eff_addr[0]) | (sz_w & (eff_addr[1:0] != 2'b00));

  assign mem_cmd = misaligned ? 2'd0 : is_ld ? 2'd1 : is_st ? 2'd2 : 2'd0;

  always_comb begin
    case (eff_addr[1:0])
      2'd0: lane_byte = rdata[7:0];
      2'd1: lane_byte = rdata[15:8];
      2'd2: lane_byte = rdata[23:16];
      default: lane_byte = rdata[31:24];
    endcase
  end
  assign lane_half = eff_addr[1] ? rdata[31:16] : rdata[15:0];

  always_comb begin
    load_val = '0;
    if (is_ld && !misaligned) begin
      case (opcode)
        OP_LDB:  load_val = {{24{lane_byte[7]}}, lane_byte};
        OP_LDBU: load_val = {24'd0, lane_byte};
        OP_LDH:  load_val = {{16{lane_half[15]}}, lane_half};
        OP_LDHU: load_val = {16'd0, lane_half};
        default: load_val = rdata;
      endcase
    end
  end

  always_comb begin
    byte_we = '0;
    wdata   = '0;
    if (is_st) begin
      if (sz_b) begin
        wdata = {4{rt[7:0]}};
        byte_we = 4'b0001 << eff_addr[1:0];
      end else if (sz_h) begin
        wdata = {2{rt[15:0]}};
        byte_we = eff_addr[1] ? 4'b1100 : 4'b0011;
      end else begin
        wdata = rt;
        byte_we = 4'b1111;
      end
      if (misaligned) byte_we = '0;
    end
  end
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic [31:0] base,
  input logic [15:0] disp,
  input logic [5:0]  opcode,
  input logic [31:0] eff_addr,
  input logic [1:0]  mem_cmd,
  input logic [3:0]  byte_we,
  input logic [31:0] load_val,
  input logic        misaligned
);
  always_comb begin
    p_disp_sum_r1: assert (eff_addr - base == {{16{disp[15]}}, disp})
      else $error("eff_addr does not differ from base by displacement");
    p_fault_quiet_r10: assert (!misaligned || (byte_we == 4'd0 && mem_cmd == 2'd0 && load_val == 32'd0))
      else $error("misaligned access still drives memory");
    p_we_means_write_r2: assert (byte_we == 4'd0 || mem_cmd == 2'd2)
      else $error("write enables without write command");
    p_byte_one_lane_r7: assert (opcode != 6'b101000 || $countones(byte_we) == 1)
      else $error("byte store enables not exactly one lane");
    p_half_pair_r8: assert (opcode != 6'b101001 || misaligned || byte_we == 4'b0011 || byte_we == 4'b1100)
      else $error("halfword store enables not an aligned pair");
    p_read_no_we_r11: assert (mem_cmd != 2'd1 || byte_we == 4'd0)
      else $error("read with write enables");
    p_byte_never_fault_r10: assert (!(opcode == 6'b101000 || opcode == 6'b100000 || opcode == 6'b100100) || !misaligned)
      else $error("byte access flagged misaligned");
  end
endmodule

bind lsu_lane_align lsu_lane_align_chk u_chk (
  .base(base), .disp(disp), .opcode(opcode), .eff_addr(eff_addr),
  .mem_cmd(mem_cmd), .byte_we(byte_we), .load_val(load_val), .misaligned(misaligned)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] base, rt, rdata;
  logic [15:0] disp;
  logic [5:0]  opcode;
  logic [31:0] eff_addr, wdata, load_val;
  logic [29:0] word_addr;
  logic [1:0]  mem_cmd;
  logic [3:0]  byte_we;
  logic        misaligned;

  int checks = 0, fails = 0, cycles = 0;

  lsu_lane_align u_dut (
    .base(base), .disp(disp), .rt(rt), .opcode(opcode), .rdata(rdata),
    .eff_addr(eff_addr), .word_addr(word_addr), .mem_cmd(mem_cmd),
    .byte_we(byte_we), .wdata(wdata), .load_val(load_val), .misaligned(misaligned)
  );

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s op=%b base=%h disp=%h actual=%h expected=%h", req, opcode, base, disp, act, exp);
    end
  endtask

  task automatic judge();
    logic [31:0] ea, e_ld, e_wd;
    logic [3:0] e_we;
    logic [1:0] e_cmd;
    logic e_mis, ld, st;
    int sz, lane;
    ea = base + 32'(signed'(disp));
    lane = int'(ea % 4);
    ld = 0; st = 0; sz = 0;
    case (opcode)
      6'b100000, 6'b100100: begin ld = 1; sz = 1; end
      6'b100001, 6'b100101: begin ld = 1; sz = 2; end
      6'b100011: begin ld = 1; sz = 4; end
      6'b101000: begin st = 1; sz = 1; end
      6'b101001: begin st = 1; sz = 2; end
      6'b101011: begin st = 1; sz = 4; end
      default: ;
    endcase
    e_mis = (sz != 0) && (lane % sz != 0);
    e_cmd = e_mis ? 2'd0 : ld ? 2'd1 : st ? 2'd2 : 2'd0;
    e_ld = 0;
    if (ld && !e_mis) begin
      e_ld = (rdata >> (8 * lane)) & ((sz == 4) ? 32'hFFFF_FFFF : (32'd1 << (8 * sz)) - 1);
      if (opcode == 6'b100000 && e_ld[7])  e_ld = e_ld + 32'hFFFF_FF00;
      if (opcode == 6'b100001 && e_ld[15]) e_ld = e_ld + 32'hFFFF_0000;
    end
    e_we = 0; e_wd = 0;
    if (st) begin
      if (sz == 1) e_wd = (rt & 32'hFF) * 32'h0101_0101;
      else if (sz == 2) e_wd = (rt & 32'hFFFF) * 32'h0001_0001;
      else e_wd = rt;
      if (!e_mis) e_we = 4'(((1 << sz) - 1) << lane);
    end
    cmp("R1 eff_addr", eff_addr, ea);
    cmp("R1 word_addr", {2'b0, word_addr}, ea / 4);
    cmp("R2 mem_cmd", {30'd0, mem_cmd}, {30'd0, e_cmd});
    cmp("R10 misaligned", {31'd0, misaligned}, {31'd0, e_mis});
    case (opcode)
      6'b100000: cmp("R3 load_val", load_val, e_ld);
      6'b100100: cmp("R4 load_val", load_val, e_ld);
      6'b100001, 6'b100101: cmp("R5 load_val", load_val, e_ld);
      6'b100011: cmp("R6 load_val", load_val, e_ld);
      default: cmp("R11 load_val", load_val, e_ld);
    endcase
    case (opcode)
      6'b101000: begin cmp("R7 byte_we", {28'd0, byte_we}, {28'd0, e_we}); cmp("R7 wdata", wdata, e_wd); end
      6'b101001: begin cmp("R8 byte_we", {28'd0, byte_we}, {28'd0, e_we}); cmp("R8 wdata", wdata, e_wd); end
      6'b101011: begin cmp("R9 byte_we", {28'd0, byte_we}, {28'd0, e_we}); cmp("R9 wdata", wdata, e_wd); end
      default:   begin cmp("R11 byte_we", {28'd0, byte_we}, {28'd0, e_we}); cmp("R11 wdata", wdata, e_wd); end
    endcase
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [5:0]  ops[11];
    logic [15:0] disps[5];
    logic [31:0] rds[3];
    ops = '{6'b100000, 6'b100001, 6'b100011, 6'b100100, 6'b100101,
            6'b101000, 6'b101001, 6'b101011, 6'b000000, 6'b100010, 6'b101110};
    disps = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFE, 16'h8003};
    rds = '{32'h80FF_7F01, 32'h1234_89AB, 32'hFFFF_FFFF};
    base = 0; disp = 0; rt = 0; opcode = 0; rdata = 0;
    @(negedge clk);
    judge();
    foreach (ops[o]) begin
      for (int b = 0; b < 4; b++) begin
        foreach (disps[d]) begin
          foreach (rds[r]) begin
            @(posedge clk);
            opcode = ops[o];
            base = 32'h1001_0000 + b;
            disp = disps[d];
            rdata = rds[r];
            rt = ~rds[r] ^ 32'h00A5_5A00;
            @(negedge clk);
            judge();
          end
        end
      end
    end
    @(posedge clk);
    opcode = 6'b101011; base = 32'hFFFF_FFFC; disp = 16'h0004; rt = 32'hDEAD_BEEF;
    @(negedge clk);
    judge();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule